// File: doc/BRIEF.md
# Ring Node Command Decoder

This block sits between a host bus and the network engine of a token-passing ring node. The host writes 8-bit command bytes. The block decodes each byte into an internal action. It keeps one pending transmit request and one receive enable, each with a buffer start address inside a 2 KB packet memory. It also keeps the broadcast-accept and long-packet settings and six status flags: transmitter available (TA), transmit acknowledged (TMA), receiver inhibited (RI), power-on (POR), excessive NAK (EXCNAK) and reconfiguration (RECON).

Strobes from the network engine drive the flags. These strobes are token arrival, reception active, reception done, transmission done, ACK received, excessive-NAK and reconfiguration. A cancel command does not take effect at once. Its effect on the flags waits for the next token. When a command write and an engine strobe arrive in the same cycle, the command is applied first and the strobe then acts on the updated state.

Top module: `ring_cmd_decoder`

## Requirements
- R1: After reset, TA, RI and POR are 1. TMA, EXCNAK, RECON, txPending, txStart, rxEnabled, bcastAccept and longPktEn are 0, and both addresses are 0.
- R2: A command of the form 00fn_n011 sets txPending and clears TA and TMA. It loads txAddr with nn×512 + f×256, where nn is bits 4:3 and f is bit 5.
- R3: When a token arrives while a transmit is pending and none is in progress, txStart pulses high for exactly one cycle on the next cycle, and txPending clears.
- R4: While a transmit is in progress, ackRcvd sets TMA. txDone sets TA and ends the transmit.
- R5: Command 0x01 clears a pending transmit that has not started. TA stays unchanged until the next token, and that token sets TA to 1.
- R6: A command of the form b0fn_n100 sets rxEnabled and clears RI. It loads rxAddr with nn×512 + f×256 and sets bcastAccept to b, which is bit 7.
- R7: rxDone sets RI and clears rxEnabled.
- R8: Command 0x02 clears rxEnabled. At the next token, RI is set if rxActive is low. If rxActive is high, RI is left for rxDone to set.
- R9: A command of the form 0000_c101 sets longPktEn to c, which is bit 3.
- R10: excNakEvt and reconEvt set EXCNAK and RECON. A command of the form 000r_p110 clears POR and EXCNAK when p (bit 3) is 1, and clears RECON when r (bit 4) is 1.
- R11: A command byte that matches none of the listed forms (for example 0x00 or 0x44) changes no output.
- R12: A command and a token in the same cycle are resolved with the command first. A transmit armed in that cycle starts on that token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte write strobe |
| cmdData | input | 8 | Command byte |
| tokenArrive | input | 1 | Token arrival strobe |
| rxActive | input | 1 | A packet is being received |
| rxDone | input | 1 | Reception finished successfully |
| txDone | input | 1 | Transmit sequence finished |
| ackRcvd | input | 1 | ACK received from the destination |
| excNakEvt | input | 1 | Excessive-NAK event |
| reconEvt | input | 1 | Ring reconfiguration event |
| txPending | output | 1 | Transmit armed and not yet started |
| txStart | output | 1 | One-cycle transmit start pulse |
| txAddr | output | 11 | Transmit buffer start address |
| rxEnabled | output | 1 | Reception into the buffer is enabled |
| rxAddr | output | 11 | Receive buffer start address |
| bcastAccept | output | 1 | Accept packets sent to ID zero |
| longPktEn | output | 1 | Long packets are handled |
| statTa | output | 1 | Transmitter available flag |
| statTma | output | 1 | Transmit acknowledged flag |
| statRi | output | 1 | Receiver inhibited flag |
| statPor | output | 1 | Power-on flag |
| statExcnak | output | 1 | Excessive-NAK flag |
| statRecon | output | 1 | Reconfiguration flag |

## Verification
The transmit path is tested three ways: a plain arm, token, ACK and done sequence; an arm followed by a cancel; and an arm written in the same cycle as the token. Together these separate the cancel path from the start path, and they show that the command is ordered ahead of the token. The receive cancel is tested once with a reception active and once with none, which shows whether RI waits for rxDone. The page and half-page bit combinations, unknown byte patterns and the two flag-clear bits are each tested separately, so a swapped field or a loose decode shows up as a wrong output.

// File: rtl/ring_cmd_pkg.sv
package ring_cmd_pkg;
  localparam int CMD_W = 8;

  typedef struct packed {
    logic       txArm;
    logic       txCancel;
    logic       rxArm;
    logic       rxCancel;
    logic       cfgWrite;
    logic       flagClear;
    logic [1:0] page;
    logic       half;
    logic       bcast;
    logic       longOk;
    logic       clrPor;
    logic       clrRecon;
  } cmdStrobe_t;
endpackage

// File: rtl/ring_cmd_decode.sv
module ring_cmd_decode
  import ring_cmd_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdData,
  output cmdStrobe_t       strobe
);
  logic [2:0] opLow;
  assign opLow = cmdData[2:0];

  always_comb begin
    strobe          = '0;
    strobe.page     = cmdData[4:3];
    strobe.half     = cmdData[5];
    strobe.bcast    = cmdData[7];
    strobe.longOk   = cmdData[3];
    strobe.clrPor   = cmdData[3];
    strobe.clrRecon = cmdData[4];
    if (cmdValid) begin
      // R5 / R8: exact cancel codes
      strobe.txCancel = (cmdData == 8'h01);
      strobe.rxCancel = (cmdData == 8'h02);
      // R6: b0fn_n100
      strobe.rxArm = (opLow == 3'b100) && !cmdData[6];
      // R2: 00fn_n011
      strobe.txArm = (opLow == 3'b011) && (cmdData[7:6] == 2'b00);
      // R9: 0000_c101
      strobe.cfgWrite = (opLow == 3'b101) && (cmdData[7:4] == 4'b0000);
      // R10: 000r_p110
      strobe.flagClear = (opLow == 3'b110) && (cmdData[7:5] == 3'b000);
    end
  end
endmodule

// File: rtl/ring_cmd_state.sv
module ring_cmd_state
  import ring_cmd_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 512,
  parameter int HALF_BYTES = PAGE_BYTES / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic              tokenArrive,
  input  logic              rxActive,
  input  logic              rxDone,
  input  logic              txDone,
  input  logic              ackRcvd,
  input  logic              excNakEvt,
  input  logic              reconEvt,
  output logic              txPending,
  output logic              txStart,
  output logic [ADDR_W-1:0] txAddr,
  output logic              rxEnabled,
  output logic [ADDR_W-1:0] rxAddr,
  output logic              bcastAccept,
  output logic              longPktEn,
  output logic              statTa,
  output logic              statTma,
  output logic              statRi,
  output logic              statPor,
  output logic              statExcnak,
  output logic              statRecon
);
  localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(HALF_BYTES);

  function automatic logic [ADDR_W-1:0] bufStart(input logic [1:0] pg, input logic hf);
    return ADDR_W'(pg) * PAGE_STEP + (hf ? HALF_STEP : '0);
  endfunction

  logic txBusy, txCancelArm, rxCancelArm;
  logic txPendEff, txCanEff, rxCanEff, startTx;

  // Command is resolved first; token logic sees the updated state (R12)
  always_comb begin
    txPendEff = strobe.txArm ? 1'b1 : (strobe.txCancel ? 1'b0 : txPending);
    txCanEff  = strobe.txArm ? 1'b0 :
                ((strobe.txCancel && !txBusy) ? 1'b1 : txCancelArm);
    rxCanEff  = strobe.rxArm ? 1'b0 : (strobe.rxCancel ? 1'b1 : rxCancelArm);
    startTx   = tokenArrive && txPendEff && !txBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPending   <= 1'b0;
      txStart     <= 1'b0;
      txBusy      <= 1'b0;
      txCancelArm <= 1'b0;
      rxCancelArm <= 1'b0;
      txAddr      <= '0;
      rxAddr      <= '0;
      rxEnabled   <= 1'b0;
      bcastAccept <= 1'b0;
      longPktEn   <= 1'b0;
      statTa      <= 1'b1;
      statTma     <= 1'b0;
      statRi      <= 1'b1;
      statPor     <= 1'b1;
      statExcnak  <= 1'b0;
      statRecon   <= 1'b0;
    end else begin
      // transmit side
      txStart     <= startTx;
      txPending   <= txPendEff && !startTx;
      txCancelArm <= txCanEff && !tokenArrive;
      if (strobe.txArm) begin
        txAddr  <= bufStart(strobe.page, strobe.half);
        statTa  <= 1'b0;
        statTma <= 1'b0;
      end
      if (startTx)               txBusy <= 1'b1;
      else if (txDone)           txBusy <= 1'b0;
      if (tokenArrive && txCanEff) statTa  <= 1'b1;
      if (ackRcvd && txBusy)       statTma <= 1'b1;
      if (txDone && txBusy)        statTa  <= 1'b1;
      // receive side
      rxCancelArm <= rxCanEff && !tokenArrive;
      if (strobe.rxArm) begin
        rxEnabled   <= 1'b1;
        rxAddr      <= bufStart(strobe.page, strobe.half);
        bcastAccept <= strobe.bcast;
        statRi      <= 1'b0;
      end
      if (strobe.rxCancel) rxEnabled <= 1'b0;
      if (tokenArrive && rxCanEff && !rxActive) statRi <= 1'b1;
      if (rxDone) begin
        statRi    <= 1'b1;
        rxEnabled <= 1'b0;
      end
      // configuration and diagnostic flags
      if (strobe.cfgWrite) longPktEn <= strobe.longOk;
      if (strobe.flagClear && strobe.clrPor) begin
        statPor    <= 1'b0;
        statExcnak <= 1'b0;
      end
      if (strobe.flagClear && strobe.clrRecon) statRecon <= 1'b0;
      if (excNakEvt) statExcnak <= 1'b1;
      if (reconEvt)  statRecon  <= 1'b1;
    end
  end

  a_r3_start_after_token: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(tokenArrive));
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);
  a_r4_ta_low_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !statTa);
  a_r4_tma_needs_flight: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statTma) |-> $past(txBusy));
  a_r7_ri_after_done: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> statRi);
  a_r10_por_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(statPor));
endmodule

// File: rtl/ring_cmd_decoder.sv
module ring_cmd_decoder
  import ring_cmd_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic              tokenArrive,
  input  logic              rxActive,
  input  logic              rxDone,
  input  logic              txDone,
  input  logic              ackRcvd,
  input  logic              excNakEvt,
  input  logic              reconEvt,
  output logic              txPending,
  output logic              txStart,
  output logic [ADDR_W-1:0] txAddr,
  output logic              rxEnabled,
  output logic [ADDR_W-1:0] rxAddr,
  output logic              bcastAccept,
  output logic              longPktEn,
  output logic              statTa,
  output logic              statTma,
  output logic              statRi,
  output logic              statPor,
  output logic              statExcnak,
  output logic              statRecon
);
  cmdStrobe_t strobe;

  ring_cmd_decode u_decode (
    .cmdValid (cmdValid),
    .cmdData  (cmdData),
    .strobe   (strobe)
  );

  ring_cmd_state #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .HALF_BYTES (PAGE_BYTES / 2)
  ) u_state (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .tokenArrive (tokenArrive),
    .rxActive    (rxActive),
    .rxDone      (rxDone),
    .txDone      (txDone),
    .ackRcvd     (ackRcvd),
    .excNakEvt   (excNakEvt),
    .reconEvt    (reconEvt),
    .txPending   (txPending),
    .txStart     (txStart),
    .txAddr      (txAddr),
    .rxEnabled   (rxEnabled),
    .rxAddr      (rxAddr),
    .bcastAccept (bcastAccept),
    .longPktEn   (longPktEn),
    .statTa      (statTa),
    .statTma     (statTma),
    .statRi      (statRi),
    .statPor     (statPor),
    .statExcnak  (statExcnak),
    .statRecon   (statRecon)
  );
endmodule

// File: tb/ring_cmd_decoder_bench.sv
`timescale 1ns/1ps
module ring_cmd_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdData = '0;
  logic tokenArrive = 1'b0, rxActive = 1'b0, rxDone = 1'b0, txDone = 1'b0;
  logic ackRcvd = 1'b0, excNakEvt = 1'b0, reconEvt = 1'b0;
  logic txPending, txStart, rxEnabled, bcastAccept, longPktEn;
  logic [10:0] txAddr, rxAddr;
  logic statTa, statTma, statRi, statPor, statExcnak, statRecon;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ring_cmd_decoder u_ring_cmd_decoder (.*);

  // {cmdValid, cmd, tok, rxAct, rxDone, txDone, ack,
  //  expected ta, tma, ri, txPending, rxEnabled, bcast, long, txAddr}
  localparam int NVEC = 17;
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 8'h13, 5'b00000, 7'b0011000, 11'd1024}, // R2 arm page 2
    {1'b0, 8'h00, 5'b10000, 7'b0010000, 11'd1024}, // R3 token starts
    {1'b0, 8'h00, 5'b00001, 7'b0110000, 11'd1024}, // R4 ack sets TMA
    {1'b0, 8'h00, 5'b00010, 7'b1110000, 11'd1024}, // R4 done sets TA
    {1'b1, 8'h3B, 5'b00000, 7'b0011000, 11'd1792}, // R2 page 3 + half
    {1'b1, 8'h01, 5'b00000, 7'b0010000, 11'd1792}, // R5 cancel, TA waits
    {1'b0, 8'h00, 5'b10000, 7'b1010000, 11'd1792}, // R5 token sets TA
    {1'b1, 8'hAC, 5'b00000, 7'b1000110, 11'd1792}, // R6 rx enable bcast
    {1'b0, 8'h00, 5'b00100, 7'b1010010, 11'd1792}, // R7 rx done
    {1'b1, 8'h84, 5'b00000, 7'b1000110, 11'd1792}, // R6 rx page 0
    {1'b1, 8'h02, 5'b00000, 7'b1000010, 11'd1792}, // R8 rx cancel
    {1'b0, 8'h00, 5'b11000, 7'b1000010, 11'd1792}, // R8 token, rx active
    {1'b0, 8'h00, 5'b00100, 7'b1010010, 11'd1792}, // R8 finishes normally
    {1'b1, 8'h0D, 5'b00000, 7'b1010011, 11'd1792}, // R9 long on
    {1'b1, 8'h05, 5'b00000, 7'b1010010, 11'd1792}, // R9 long off
    {1'b1, 8'h44, 5'b00000, 7'b1010010, 11'd1792}, // R11 bad rx form
    {1'b1, 8'h00, 5'b00000, 7'b1010010, 11'd1792}  // R11 zero byte
  };
  localparam int VREQ [NVEC] = '{2, 3, 4, 4, 2, 5, 5, 6, 7, 6, 8, 8, 8, 9, 9, 11, 11};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cmdValid = 1'b0; cmdData = '0; tokenArrive = 1'b0; rxActive = 1'b0;
    rxDone = 1'b0; txDone = 1'b0; ackRcvd = 1'b0; excNakEvt = 1'b0; reconEvt = 1'b0;
  endtask

  task automatic cmdCycle(input logic [7:0] c, input logic tok);
    @(negedge clk);
    cmdValid = 1'b1; cmdData = c; tokenArrive = tok;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", {26'd0, statTa, statTma, statRi, statPor, statExcnak, statRecon}, 32'b101100);
    chk("R1 paths", {26'd0, txPending, txStart, rxEnabled, bcastAccept, longPktEn, 1'b0}, 32'd0);
    chk("R1 addrs", {10'd0, txAddr, rxAddr}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      @(negedge clk);
      cmdValid = v[31]; cmdData = v[30:23]; tokenArrive = v[22]; rxActive = v[21];
      rxDone = v[20]; txDone = v[19]; ackRcvd = v[18];
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VREQ[i], i),
          {14'd0, statTa, statTma, statRi, txPending, rxEnabled, bcastAccept, longPktEn, txAddr},
          {14'd0, v[17:0]});
      idle();
    end

    // R6 receive address with half-page, no broadcast
    cmdCycle(8'h2C, 1'b0);
    chk("R6 rxAddr", {21'd0, rxAddr}, 32'd768);
    chk("R6 bcast", {31'd0, bcastAccept}, 32'd0);
    // R8 cancel with no reception: RI waits for token
    cmdCycle(8'h02, 1'b0);
    chk("R8 ri before token", {31'd0, statRi}, 32'd0);
    @(negedge clk); tokenArrive = 1'b1;
    @(negedge clk); idle();
    chk("R8 ri at token", {31'd0, statRi}, 32'd1);

    // R10 flag set and selective clear
    @(negedge clk); excNakEvt = 1'b1; reconEvt = 1'b1;
    @(negedge clk); idle();
    chk("R10 set", {29'd0, statPor, statExcnak, statRecon}, 32'b111);
    cmdCycle(8'h16, 1'b0);
    chk("R10 r only", {29'd0, statPor, statExcnak, statRecon}, 32'b110);
    cmdCycle(8'h0E, 1'b0);
    chk("R10 p clear", {29'd0, statPor, statExcnak, statRecon}, 32'b000);

    // R12 arm and token in the same cycle
    cmdCycle(8'h0B, 1'b1);
    chk("R12 start", {19'd0, txStart, txPending, statTa, txAddr}, {19'd0, 1'b1, 1'b0, 1'b0, 11'd512});
    @(negedge clk);
    chk("R3 pulse ends", {31'd0, txStart}, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule